// File: doc/BRIEF.md
# Device Interrupt Routing Controller

This block collects level-sensitive interrupt requests from a fixed set of device sources and turns each one into a single interrupt message addressed to a processor. Every source owns two 64-bit registers. The routing register names the target processor id and the vector to deliver. The control register holds a mask bit and a pending flag. Software programs the routing, then clears the mask to arm a source.

Once a source is armed and its request line is high, the block accepts it. Acceptance sets the mask and the pending flag of that source in the same clock. One clock later the block emits a one-cycle message on its interrupt output. The message carries the routed processor id and vector. Because acceptance masks the source, a request that stays high fires only once. The source stays silent until software writes its control register to unmask it. Software clears the pending flag with a separate clear bit.

A two-state dispatch machine sequences the work. In `DSP_IDLE` it arbitrates among eligible sources, lowest index first. The transition `ACCEPT` (some source eligible) moves it to `DSP_POST`. In `DSP_POST` the message is driven for one cycle, and the transition `DONE` (unconditional) returns it to `DSP_IDLE`. While no source is eligible, `DSP_IDLE` stays in `DSP_IDLE`. Sources that lose arbitration keep their request and are considered again on the next pass through `DSP_IDLE`. An access to an unmapped offset returns zero and raises a one-cycle error flag.

Top module: `dev_irq_router`

## Requirements
- R1: The routing register of source i is at byte offset 8*i, and the control register of source i is at byte offset 0x400 + 8*i. The register index is the offset shifted right by 3, so address bits 2:0 are ignored. Read data and the error flag appear in the cycle after the read strobe.
- R2: In the routing register, a write loads the processor id from bits 12:8 and the vector from bits 5:0; all other written bits are dropped. A read returns the two fields in the same positions, with every other bit zero.
- R3: A write to the control register loads the mask from bit 2. Writing 1 to bit 1 clears the pending flag, and writing 0 to bit 1 leaves it unchanged. A read returns the mask in bit 2 and the pending flag in bit 0, with every other bit zero.
- R4: After reset every source is masked, no source is pending, every routing register reads as zero, and the interrupt output is idle.
- R5: A request from a masked source has no effect. No message is posted, and the pending flag is unchanged.
- R6: When a source's request is high while its mask is clear, the block sets that source's mask and pending flag. In the next cycle it drives a single one-cycle message with the routed processor id (5 bits) and vector (6 bits). A request that stays high after this posts nothing more.
- R7: When several sources are eligible, the lowest index is accepted first. The others are accepted later, in index order, while their requests stay high. The message valid is never high in two consecutive cycles.
- R8: A read or write of an offset outside both register ranges returns zero read data and pulses the error flag for one cycle. Such a write changes no register. An access to a mapped offset does not raise the error flag.
- R9: When a source is accepted in the same cycle that software writes its control register, acceptance wins. The mask and pending flag both end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after the read strobe |
| reg_err | output | 1 | One-cycle pulse for an unmapped access |
| dev_req | input | 8 | Level-sensitive request per source |
| irq_valid | output | 1 | One-cycle interrupt message valid |
| irq_cpu | output | 5 | Target processor id of the message |
| irq_vec | output | 6 | Vector of the message |

## Verification
The hardest case to reach is the clock in which hardware accepts a source while software writes that source's control register to clear its mask and pending flag. The stimulus first arms the source while its request is low. Then, on a single clock edge, it raises the request and issues the conflicting control write together, and reads the control register back. A second hard case is several requests held high at once. The stimulus arms three sources with distinct routes while their lines are low and then raises all three together. The scoreboard must see the three messages in index order, with an idle cycle between each.

// File: rtl/dev_irq_pkg.sv
package dev_irq_pkg;

    localparam int CPU_W    = 5;
    localparam int VEC_W    = 6;
    localparam int DATA_W   = 64;

    // field positions inside the 64-bit registers
    localparam int CPU_LSB  = 8;
    localparam int VEC_LSB  = 0;
    localparam int MASK_BIT = 2;
    localparam int PCLR_BIT = 1;
    localparam int PEND_BIT = 0;

    typedef struct packed {
        logic [CPU_W-1:0] cpu;
        logic [VEC_W-1:0] vec;
    } route_t;

    typedef enum logic {
        DSP_IDLE = 1'b0,
        DSP_POST = 1'b1
    } dsp_state_t;

endpackage

// File: rtl/dev_irq_regs.sv
module dev_irq_regs
    import dev_irq_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int ADDR_W   = 12,
    parameter int CTL_BASE = 'h400,
    localparam int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic                        acc_en,
    input  logic [IDX_W-1:0]            acc_idx,
    output route_t [NUM_SRC-1:0]        route_q,
    output logic   [NUM_SRC-1:0]        mask_q,
    output logic   [NUM_SRC-1:0]        pend_q,
    output logic   [DATA_W-1:0]         rdata,
    output logic                        err
);

    localparam logic [ADDR_W-1:0] ROUTE_END = ADDR_W'(NUM_SRC * 8);
    localparam logic [ADDR_W-1:0] CTL_LO    = ADDR_W'(CTL_BASE);
    localparam logic [ADDR_W-1:0] CTL_HI    = ADDR_W'(CTL_BASE + NUM_SRC * 8);

    logic              route_hit;
    logic              ctl_hit;
    logic [ADDR_W-1:0] ctl_off;
    logic [IDX_W-1:0]  route_idx;
    logic [IDX_W-1:0]  ctl_idx;
    logic [DATA_W-1:0] rd_next;
    logic              err_next;

    assign route_hit = (addr < ROUTE_END);
    assign ctl_hit   = (addr >= CTL_LO) && (addr < CTL_HI);
    assign ctl_off   = addr - CTL_LO;
    assign route_idx = addr[3 +: IDX_W];
    assign ctl_idx   = ctl_off[3 +: IDX_W];

    wire unused_bits = ^{wdata[DATA_W-1:CPU_LSB+CPU_W],
                         wdata[CPU_LSB-1:VEC_LSB+VEC_W],
                         addr[2:0], ctl_off};

    // register storage: hardware acceptance has priority over software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= '0;
            mask_q  <= '1;
            pend_q  <= '0;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (wr_en && route_hit && route_idx == IDX_W'(i)) begin
                    route_q[i].cpu <= wdata[CPU_LSB +: CPU_W];
                    route_q[i].vec <= wdata[VEC_LSB +: VEC_W];
                end
                if (acc_en && acc_idx == IDX_W'(i)) begin
                    mask_q[i] <= 1'b1;
                    pend_q[i] <= 1'b1;
                end else if (wr_en && ctl_hit && ctl_idx == IDX_W'(i)) begin
                    mask_q[i] <= wdata[MASK_BIT];
                    if (wdata[PCLR_BIT]) begin
                        pend_q[i] <= 1'b0;
                    end
                end
            end
        end
    end

    always_comb begin
        rd_next  = '0;
        err_next = 1'b0;
        if (rd_en) begin
            if (route_hit) begin
                rd_next[CPU_LSB +: CPU_W] = route_q[route_idx].cpu;
                rd_next[VEC_LSB +: VEC_W] = route_q[route_idx].vec;
            end else if (ctl_hit) begin
                rd_next[MASK_BIT] = mask_q[ctl_idx];
                rd_next[PEND_BIT] = pend_q[ctl_idx];
            end else begin
                err_next = 1'b1;
            end
        end
        if (wr_en && !route_hit && !ctl_hit) begin
            err_next = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            rdata <= rd_next;
            err   <= err_next;
        end
    end

endmodule

// File: rtl/dev_irq_arb.sv
module dev_irq_arb #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] elig,
    output logic               found,
    output logic [IDX_W-1:0]   win_idx
);

    // fixed priority, lowest index wins
    always_comb begin
        found   = |elig;
        win_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dev_irq_dispatch.sv
module dev_irq_dispatch
    import dev_irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 found,
    input  logic [IDX_W-1:0]     win_idx,
    input  route_t [NUM_SRC-1:0] route_q,
    output logic                 acc_en,
    output logic [IDX_W-1:0]     acc_idx,
    output logic                 irq_valid,
    output logic [CPU_W-1:0]     irq_cpu,
    output logic [VEC_W-1:0]     irq_vec
);

    dsp_state_t state_q;
    dsp_state_t state_d;

    // next state and acceptance
    always_comb begin
        state_d = state_q;
        acc_en  = 1'b0;
        unique case (state_q)
            DSP_IDLE: begin
                if (found) begin
                    acc_en  = 1'b1;
                    state_d = DSP_POST;
                end
            end
            DSP_POST: begin
                state_d = DSP_IDLE;
            end
        endcase
    end

    assign acc_idx = win_idx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs: message payload captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_cpu   <= '0;
            irq_vec   <= '0;
        end else begin
            irq_valid <= acc_en;
            if (acc_en) begin
                irq_cpu <= route_q[win_idx].cpu;
                irq_vec <= route_q[win_idx].vec;
            end
        end
    end

endmodule

// File: rtl/dev_irq_router.sv
module dev_irq_router
    import dev_irq_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int ADDR_W   = 12,
    parameter int CTL_BASE = 'h400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic                reg_rd_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                reg_err,
    input  logic [NUM_SRC-1:0]  dev_req,
    output logic                irq_valid,
    output logic [CPU_W-1:0]    irq_cpu,
    output logic [VEC_W-1:0]    irq_vec
);

    localparam int IDX_W = $clog2(NUM_SRC);

    route_t [NUM_SRC-1:0] route_q;
    logic   [NUM_SRC-1:0] src_mask;
    logic   [NUM_SRC-1:0] src_pend;
    logic   [NUM_SRC-1:0] elig;
    logic                 found;
    logic   [IDX_W-1:0]   win_idx;
    logic                 acc_en;
    logic   [IDX_W-1:0]   acc_idx;

    assign elig = dev_req & ~src_mask;

    dev_irq_regs #(
        .NUM_SRC  (NUM_SRC),
        .ADDR_W   (ADDR_W),
        .CTL_BASE (CTL_BASE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .rd_en   (reg_rd_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .acc_en  (acc_en),
        .acc_idx (acc_idx),
        .route_q (route_q),
        .mask_q  (src_mask),
        .pend_q  (src_pend),
        .rdata   (reg_rdata),
        .err     (reg_err)
    );

    dev_irq_arb #(
        .NUM_SRC (NUM_SRC)
    ) u_arb (
        .elig    (elig),
        .found   (found),
        .win_idx (win_idx)
    );

    dev_irq_dispatch #(
        .NUM_SRC (NUM_SRC)
    ) u_dispatch (
        .clk       (clk),
        .rst_n     (rst_n),
        .found     (found),
        .win_idx   (win_idx),
        .route_q   (route_q),
        .acc_en    (acc_en),
        .acc_idx   (acc_idx),
        .irq_valid (irq_valid),
        .irq_cpu   (irq_cpu),
        .irq_vec   (irq_vec)
    );

endmodule

// File: rtl/dev_irq_router_chk.sv
module dev_irq_router_chk #(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] dev_req,
    input logic [NUM_SRC-1:0] src_mask,
    input logic [NUM_SRC-1:0] src_pend,
    input logic               acc_en,
    input logic [IDX_W-1:0]   acc_idx,
    input logic               irq_valid,
    input logic               reg_rd_en,
    input logic               reg_wr_en,
    input logic               reg_err,
    input logic [63:0]        reg_rdata
);

    // R7
    post_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    // R5
    post_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $past(|(dev_req & ~src_mask)));

    // R6
    accept_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> (src_mask[$past(acc_idx)] && src_pend[$past(acc_idx)]));

    // R7
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> (((dev_req & ~src_mask) & ~({NUM_SRC{1'b1}} << acc_idx)) == '0));

    // R8
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> (reg_rdata == '0));

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $past(reg_rd_en || reg_wr_en));

endmodule

bind dev_irq_router dev_irq_router_chk #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_req   (dev_req),
    .src_mask  (src_mask),
    .src_pend  (src_pend),
    .acc_en    (acc_en),
    .acc_idx   (acc_idx),
    .irq_valid (irq_valid),
    .reg_rd_en (reg_rd_en),
    .reg_wr_en (reg_wr_en),
    .reg_err   (reg_err),
    .reg_rdata (reg_rdata)
);

// File: tb/dev_irq_router_bench.sv
module dev_irq_router_bench;

    localparam int NSRC = 8;
    localparam logic [11:0] CTL = 12'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        reg_err;
    logic [NSRC-1:0] dev_req = '0;
    logic        irq_valid;
    logic [4:0]  irq_cpu;
    logic [5:0]  irq_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [10:0] exp_q [$];
    logic [63:0] rd_val;
    logic        rd_err;
    logic        wr_err;
    logic        prev_valid = 1'b0;

    always #4 clk = ~clk;

    dev_irq_router u_dev_irq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_err   (reg_err),
        .dev_req   (dev_req),
        .irq_valid (irq_valid),
        .irq_cpu   (irq_cpu),
        .irq_vec   (irq_vec)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        wr_err = reg_err;
    endtask

    task automatic reg_read(input logic [11:0] a);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        rd_val = reg_rdata;
        rd_err = reg_err;
    endtask

    task automatic expect_post(input logic [4:0] cpu, input logic [5:0] vec);
        exp_q.push_back({cpu, vec});
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (irq_valid) begin
                n_chk++;
                if (prev_valid) begin
                    n_bad++;
                    $display("FAIL R7 back-to-back valid actual=1 expected=0");
                end
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R5 unexpected post actual=%h expected=none", {irq_cpu, irq_vec});
                end else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    if ({irq_cpu, irq_vec} !== e) begin
                        n_bad++;
                        $display("FAIL R6 post payload actual=%h expected=%h", {irq_cpu, irq_vec}, e);
                    end
                end
            end
            prev_valid = irq_valid;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R4 reset state
        chk("R4 irq_valid", {63'd0, irq_valid}, 64'd0);
        for (int i = 0; i < NSRC; i++) begin
            reg_read(CTL + 12'(8 * i));
            chk("R4 ctl reset", rd_val, 64'h4);
            reg_read(12'(8 * i));
            chk("R4 route reset", rd_val, 64'h0);
        end

        // R2 routing fields, junk bits dropped
        reg_write(12'h018, 64'h8000_0000_0000_35EA);
        reg_read(12'h018);
        chk("R2 route3", rd_val, 64'h152A);

        // R5 masked request ignored
        @(negedge clk); dev_req[3] = 1'b1;
        repeat (5) @(negedge clk);
        reg_read(CTL + 12'h18);
        chk("R5 masked pend", rd_val, 64'h4);

        // R6 unmask while request held: one post
        expect_post(5'h15, 6'h2A);
        reg_write(CTL + 12'h18, 64'h0);
        repeat (8) @(negedge clk);
        chk("R6 post seen", 64'(exp_q.size()), 64'd0);
        reg_read(CTL + 12'h18);
        chk("R6 mask+pend", rd_val, 64'h5);

        // R3 bit1 = 0 keeps pend, bit1 = 1 clears
        reg_write(CTL + 12'h18, 64'h4);
        reg_read(CTL + 12'h18);
        chk("R3 pend kept", rd_val, 64'h5);
        reg_write(CTL + 12'h18, 64'h6);
        reg_read(CTL + 12'h18);
        chk("R3 pend cleared", rd_val, 64'h4);
        @(negedge clk); dev_req[3] = 1'b0;

        // R1 misaligned offset maps to index offset>>3
        reg_write(12'h00B, 64'h0111);
        reg_read(12'h008);
        chk("R1 misaligned route1", rd_val, 64'h0111);
        reg_write(12'h028, 64'h1F3F);
        reg_read(12'h02D);
        chk("R1 route5 read", rd_val, 64'h1F3F);

        // R7 priority among three held requests
        reg_write(CTL + 12'h08, 64'h0);
        reg_write(CTL + 12'h18, 64'h0);
        reg_write(CTL + 12'h28, 64'h0);
        expect_post(5'h01, 6'h11);
        expect_post(5'h15, 6'h2A);
        expect_post(5'h1F, 6'h3F);
        @(negedge clk); dev_req = 8'b0010_1010;
        repeat (12) @(negedge clk);
        chk("R7 all three posted", 64'(exp_q.size()), 64'd0);
        reg_read(CTL + 12'h08);
        chk("R7 ctl1", rd_val, 64'h5);
        reg_read(CTL + 12'h28);
        chk("R7 ctl5", rd_val, 64'h5);
        @(negedge clk); dev_req = '0;

        // R8 unmapped accesses
        reg_read(12'h200);
        chk("R8 unmapped data", rd_val, 64'h0);
        chk("R8 unmapped err", {63'd0, rd_err}, 64'd1);
        @(negedge clk);
        chk("R8 err one cycle", {63'd0, reg_err}, 64'd0);
        reg_read(12'h038);
        chk("R8 mapped edge err", {63'd0, rd_err}, 64'd0);
        reg_read(CTL + 12'h38);
        chk("R8 ctl7 edge", rd_val, 64'h4);
        chk("R8 ctl7 edge err", {63'd0, rd_err}, 64'd0);
        reg_read(CTL + 12'h40);
        chk("R8 past ctl err", {63'd0, rd_err}, 64'd1);
        chk("R8 past ctl data", rd_val, 64'h0);
        reg_write(12'h040, 64'h1F3F);
        chk("R8 write err", {63'd0, wr_err}, 64'd1);
        reg_read(12'h038);
        chk("R8 route7 untouched", rd_val, 64'h0);

        // R9 accept collides with control write
        reg_write(12'h010, 64'h0209);
        reg_write(CTL + 12'h10, 64'h0);
        expect_post(5'h02, 6'h09);
        @(negedge clk);
        dev_req[2] = 1'b1;
        reg_wr_en = 1'b1; reg_addr = CTL + 12'h10; reg_wdata = 64'h2;
        @(negedge clk);
        reg_wr_en = 1'b0;
        repeat (4) @(negedge clk);
        reg_read(CTL + 12'h10);
        chk("R9 accept wins", rd_val, 64'h5);
        @(negedge clk); dev_req = '0;
        repeat (4) @(negedge clk);
        chk("R9 post seen", 64'(exp_q.size()), 64'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule